// File: doc/BRIEF.md
# Parallel NOR Flash Command Interface

This block models the command side of a parallel NOR flash. Bus writes are decoded either as command bytes or as data, depending on where a multi-cycle write sequence stands. The supported operations are single-word program, sector erase with confirm, buffered write, status clear, lock/unlock sequences and the selection of the read source. A bus read returns one of two things: a word from the internal storage array, or the 8-bit status byte copied into every device lane. For identification and query reads the block only reports the mode on `rd_mode`. A separate block supplies that data, and `rdata` reads zero here.

Operations take effect at once, with no programming or erase delay. When the `array_ro` input is high, the array is read-only: program and erase sequences still complete, but they set error bits in the status byte and leave the storage untouched.

The state machine has seven states:
- `ST_IDLE`: decodes commands.
- `ST_PROG`: waits for the program data word.
- `ST_ERASE`: waits for the erase confirm.
- `ST_LOCK`: waits for the lock sub-command.
- `ST_BCOUNT`: waits for the buffer word count.
- `ST_BDATA`: takes the buffer data words.
- `ST_BCONF`: waits for the buffer confirm.

Its transitions are:
- Idle goes to the program, erase, lock or buffer-count state on the matching command.
- Program always returns to idle.
- Erase, lock and buffer-confirm return to idle with status mode on a recognised value, and with array mode otherwise.
- Buffer-count goes to buffer-data.
- Buffer-data goes to buffer-confirm after the last word.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, the status byte is 0x80 and `rd_mode` is 0 (array). Every array word reads as all ones.
- R2: In idle, `rd_mode` selects the read source with this encoding: 0 = array, 1 = status, 2 = identification, 3 = query. Write command 0xFF selects 0, 0x70 selects 1, 0x90 selects 2 and 0x98 selects 3. In modes 2 and 3 `rdata` reads 0. Commands are compared on `wdata[7:0]`.
- R3: Command 0x50 clears the status byte to 0x00 and selects status mode.
- R4: After command 0x10 or 0x40, the next write stores `wdata` at `addr`. That write sets status bit 7 and the block returns to idle in status mode.
- R5: Command 0x20 or 0x28 followed by 0xD0 sets every word of the aligned sector of SECTOR_WORDS words containing `addr` to all ones, and sets status bit 7. If the second write is 0xFF, or any other value, the erase is abandoned and the block enters array mode with the array unchanged.
- R6: With `array_ro` high, the array never changes. A program or buffer data write sets status bit 4 (0x10), and an erase confirm sets status bit 5 (0x20). Bit 7 is still set.
- R7: Command 0xE8 sets status bit 7. The next write gives N = `wdata[DEV_W-1:0]`; the following N+1 writes each store their data. A final 0xD0 returns to idle in status mode, and any other value returns to idle in array mode.
- R8: While any sequence is pending (any state other than idle), reads return the status and `rd_mode` is 1.
- R9: Command 0x60 followed by 0x01 or 0xD0 sets status bit 7 and selects status mode. Followed by 0xFF or any other value, it selects array mode.
- R10: A write in idle whose command byte is not listed above selects array mode and changes neither the status nor the array.
- R11: A status read returns the 8-bit status, zero-extended to DEV_W, in every DEV_W-bit lane of `rdata`.
- R12: `rdata` is registered. It updates at the clock edge that samples `rd_en`, from the mode and array as they were before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data or command byte in bits 7:0 |
| array_ro | input | 1 | Array is read-only when high |
| rdata | output | DATA_W | Registered read data |
| rd_mode | output | 2 | Current read source (0 array, 1 status, 2 ident, 3 query) |

## Verification
The hardest situation to reach from the ports is the error path inside a sequence. The read-only input must be high exactly when a program data word, buffer data word or erase confirm arrives, and the error bits only become visible after a later status read, because clears and other commands in between can hide them. The stimulus toggles `array_ro` at random between complete command sequences. It mixes in random confirm values, random buffer counts and random command bytes, and directed cases pin down each error bit, the erase abort and sector alignment. After every sequence, a bench model of the array, status and mode predicts the value of the read that follows.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_ERASE,
        ST_LOCK,
        ST_BCOUNT,
        ST_BDATA,
        ST_BCONF
    } fstate_t;

    typedef enum logic [1:0] {
        RM_ARRAY  = 2'd0,
        RM_STATUS = 2'd1,
        RM_IDENT  = 2'd2,
        RM_QUERY  = 2'd3
    } rmode_t;

    localparam logic [7:0] C_ARRAY   = 8'hFF;
    localparam logic [7:0] C_RSTAT   = 8'h70;
    localparam logic [7:0] C_CLR     = 8'h50;
    localparam logic [7:0] C_IDENT   = 8'h90;
    localparam logic [7:0] C_QUERY   = 8'h98;
    localparam logic [7:0] C_PROG_A  = 8'h10;
    localparam logic [7:0] C_PROG_B  = 8'h40;
    localparam logic [7:0] C_ERASE_A = 8'h20;
    localparam logic [7:0] C_ERASE_B = 8'h28;
    localparam logic [7:0] C_CONFIRM = 8'hD0;
    localparam logic [7:0] C_LOCK    = 8'h60;
    localparam logic [7:0] C_LOCKSET = 8'h01;
    localparam logic [7:0] C_BUFFER  = 8'hE8;

    localparam logic [7:0] S_READY   = 8'h80;
    localparam logic [7:0] S_ERR_ERS = 8'h20;
    localparam logic [7:0] S_ERR_PRG = 8'h10;

endpackage

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int DEV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [7:0]       cmd,
    input  logic [DEV_W-1:0] cnt_in,
    input  logic             array_ro,
    output fstate_t          state,
    output logic [7:0]       status,
    output rmode_t           rd_mode,
    output logic             mem_we,
    output logic             mem_erase
);

    fstate_t          nxt_state;
    rmode_t           mode_q, nxt_mode;
    logic [7:0]       nxt_status;
    logic [DEV_W-1:0] cnt_q, nxt_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            mode_q <= RM_ARRAY;
            status <= S_READY;
            cnt_q  <= '0;
        end else begin
            state  <= nxt_state;
            mode_q <= nxt_mode;
            status <= nxt_status;
            cnt_q  <= nxt_cnt;
        end
    end

    always_comb begin
        nxt_state  = state;
        nxt_mode   = mode_q;
        nxt_status = status;
        nxt_cnt    = cnt_q;
        mem_we     = 1'b0;
        mem_erase  = 1'b0;
        if (wr_en) begin
            unique case (state)
                ST_IDLE: begin
                    unique case (cmd)
                        C_PROG_A, C_PROG_B: begin
                            nxt_state = ST_PROG;
                            nxt_mode  = RM_STATUS;
                        end
                        C_ERASE_A, C_ERASE_B: begin
                            nxt_state = ST_ERASE;
                            nxt_mode  = RM_STATUS;
                        end
                        C_LOCK: begin
                            nxt_state = ST_LOCK;
                            nxt_mode  = RM_STATUS;
                        end
                        C_BUFFER: begin
                            nxt_state  = ST_BCOUNT;
                            nxt_mode   = RM_STATUS;
                            nxt_status = status | S_READY;
                        end
                        C_CLR: begin
                            nxt_status = 8'h00;
                            nxt_mode   = RM_STATUS;
                        end
                        C_RSTAT: nxt_mode = RM_STATUS;
                        C_IDENT: nxt_mode = RM_IDENT;
                        C_QUERY: nxt_mode = RM_QUERY;
                        default: nxt_mode = RM_ARRAY;
                    endcase
                end
                ST_PROG: begin
                    if (array_ro) nxt_status = status | S_ERR_PRG | S_READY;
                    else begin
                        mem_we     = 1'b1;
                        nxt_status = status | S_READY;
                    end
                    nxt_state = ST_IDLE;
                    nxt_mode  = RM_STATUS;
                end
                ST_ERASE: begin
                    nxt_state = ST_IDLE;
                    if (cmd == C_CONFIRM) begin
                        if (array_ro) nxt_status = status | S_ERR_ERS | S_READY;
                        else begin
                            mem_erase  = 1'b1;
                            nxt_status = status | S_READY;
                        end
                        nxt_mode = RM_STATUS;
                    end else nxt_mode = RM_ARRAY;
                end
                ST_LOCK: begin
                    nxt_state = ST_IDLE;
                    if (cmd == C_LOCKSET || cmd == C_CONFIRM) begin
                        nxt_status = status | S_READY;
                        nxt_mode   = RM_STATUS;
                    end else nxt_mode = RM_ARRAY;
                end
                ST_BCOUNT: begin
                    nxt_cnt   = cnt_in;
                    nxt_state = ST_BDATA;
                end
                ST_BDATA: begin
                    if (array_ro) nxt_status = status | S_ERR_PRG;
                    else mem_we = 1'b1;
                    if (cnt_q == '0) nxt_state = ST_BCONF;
                    else nxt_cnt = cnt_q - 1'b1;
                end
                ST_BCONF: begin
                    nxt_state = ST_IDLE;
                    if (cmd == C_CONFIRM) begin
                        nxt_status = status | S_READY;
                        nxt_mode   = RM_STATUS;
                    end else nxt_mode = RM_ARRAY;
                end
                default: begin
                    nxt_state = ST_IDLE;
                    nxt_mode  = RM_ARRAY;
                end
            endcase
        end
    end

    assign rd_mode = (state == ST_IDLE) ? mode_q : RM_STATUS;

endmodule

// File: rtl/flash_cmd_array.sv
module flash_cmd_array #(
    parameter int ADDR_W       = 6,
    parameter int DATA_W       = 16,
    parameter int SECTOR_WORDS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              erase,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rword
);

    localparam int DEPTH    = 1 << ADDR_W;
    localparam int SEC_BITS = $clog2(SECTOR_WORDS);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (rst) mem[i] <= '1;
            else if (we && addr == ADDR_W'(i)) mem[i] <= wdata;
            else if (erase && addr[ADDR_W-1:SEC_BITS] == (ADDR_W - SEC_BITS)'(i >> SEC_BITS))
                mem[i] <= '1;
        end
    end

    assign rword = mem[addr];

endmodule

// File: rtl/flash_cmd_rdmux.sv
module flash_cmd_rdmux
    import flash_cmd_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEV_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  rmode_t            rd_mode,
    input  logic [DATA_W-1:0] rword,
    input  logic [7:0]        status,
    output logic [DATA_W-1:0] rdata
);

    localparam int LANES = DATA_W / DEV_W;

    logic [DATA_W-1:0] stat_rep;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign stat_rep[l*DEV_W +: DEV_W] = DEV_W'(status);
    end

    always_ff @(posedge clk) begin
        if (rst) rdata <= '0;
        else if (rd_en) begin
            unique case (rd_mode)
                RM_ARRAY:  rdata <= rword;
                RM_STATUS: rdata <= stat_rep;
                default:   rdata <= '0;
            endcase
        end
    end

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W       = 6,
    parameter int DATA_W       = 16,
    parameter int DEV_W        = 8,
    parameter int SECTOR_WORDS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              array_ro,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        rd_mode
);

    fstate_t           fsm_state;
    rmode_t            mode_w;
    logic [7:0]        status_q;
    logic              mem_we, mem_erase;
    logic [DATA_W-1:0] rword;

    flash_cmd_fsm #(.DEV_W(DEV_W)) u_fsm (
        .clk(clk), .rst(rst), .wr_en(wr_en), .cmd(wdata[7:0]),
        .cnt_in(wdata[DEV_W-1:0]), .array_ro(array_ro),
        .state(fsm_state), .status(status_q), .rd_mode(mode_w),
        .mem_we(mem_we), .mem_erase(mem_erase)
    );

    flash_cmd_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECTOR_WORDS(SECTOR_WORDS)) u_array (
        .clk(clk), .rst(rst), .we(mem_we), .erase(mem_erase),
        .addr(addr), .wdata(wdata), .rword(rword)
    );

    flash_cmd_rdmux #(.DATA_W(DATA_W), .DEV_W(DEV_W)) u_rdmux (
        .clk(clk), .rst(rst), .rd_en(rd_en), .rd_mode(mode_w),
        .rword(rword), .status(status_q), .rdata(rdata)
    );

    assign rd_mode = mode_w;

endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk
    import flash_cmd_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [DATA_W-1:0] wdata,
    input logic              array_ro,
    input logic [1:0]        rd_mode,
    input fstate_t           fsm_state,
    input logic [7:0]        status_q,
    input logic              mem_we,
    input logic              mem_erase
);

    p_reset_ready_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (status_q == 8'h80 && fsm_state == ST_IDLE && rd_mode == 2'd0));

    p_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && fsm_state == ST_IDLE && wdata[7:0] == 8'h50) |=> (status_q == 8'h00));

    p_single_op_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_we, mem_erase}));

    p_erase_ready_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && fsm_state == ST_ERASE && wdata[7:0] == 8'hD0) |=> status_q[7]);

    p_ro_nowrite_r6: assert property (@(posedge clk) disable iff (rst)
        array_ro |-> (!mem_we && !mem_erase));

    p_ro_prog_err_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && fsm_state == ST_PROG && array_ro) |=> status_q[4]);

    p_seq_status_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && fsm_state == ST_IDLE && wdata[7:0] == 8'h10) |=> (rd_mode == 2'd1));

    p_unknown_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && fsm_state == ST_IDLE && wdata[7:0] == 8'h00) |=> (rd_mode == 2'd0 && $stable(status_q)));

endmodule

bind flash_cmd_ctrl flash_cmd_chk #(.DATA_W(DATA_W)) i_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wdata(wdata), .array_ro(array_ro),
    .rd_mode(rd_mode), .fsm_state(fsm_state), .status_q(status_q),
    .mem_we(mem_we), .mem_erase(mem_erase)
);

// File: tb/test_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module test_flash_cmd_ctrl;

    localparam int ADDR_W = 6;
    localparam int DATA_W = 16;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int SECW   = 8;

    logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0, array_ro = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic [1:0] rd_mode;

    always #4 clk = ~clk;

    flash_cmd_ctrl i_flash_cmd_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .array_ro(array_ro), .rdata(rdata), .rd_mode(rd_mode)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // reference model
    logic [DATA_W-1:0] m_mem [DEPTH];
    logic [7:0] m_stat;
    int m_st;      // 0 idle 1 prog 2 erase 3 lock 4 bcount 5 bdata 6 bconf
    int m_mode;
    int m_cnt;

    function automatic int eff_mode();
        return (m_st != 0) ? 1 : m_mode;
    endfunction

    function automatic logic [DATA_W-1:0] exp_read(input int a);
        case (eff_mode())
            0: return m_mem[a];
            1: return {m_stat, m_stat};
            default: return '0;
        endcase
    endfunction

    task automatic model_wr(input int a, input logic [DATA_W-1:0] d);
        logic [7:0] c = d[7:0];
        case (m_st)
            0: case (c)
                8'h10, 8'h40: begin m_st = 1; m_mode = 1; end
                8'h20, 8'h28: begin m_st = 2; m_mode = 1; end
                8'h60: begin m_st = 3; m_mode = 1; end
                8'hE8: begin m_st = 4; m_mode = 1; m_stat |= 8'h80; end
                8'h50: begin m_stat = 0; m_mode = 1; end
                8'h70: m_mode = 1;
                8'h90: m_mode = 2;
                8'h98: m_mode = 3;
                default: m_mode = 0;
            endcase
            1: begin
                if (array_ro) m_stat |= 8'h10; else m_mem[a] = d;
                m_stat |= 8'h80; m_st = 0; m_mode = 1;
            end
            2: begin
                m_st = 0;
                if (c == 8'hD0) begin
                    if (array_ro) m_stat |= 8'h20;
                    else for (int i = 0; i < DEPTH; i++) if (i / SECW == a / SECW) m_mem[i] = '1;
                    m_stat |= 8'h80; m_mode = 1;
                end else m_mode = 0;
            end
            3: begin
                m_st = 0;
                if (c == 8'h01 || c == 8'hD0) begin m_stat |= 8'h80; m_mode = 1; end
                else m_mode = 0;
            end
            4: begin m_cnt = c; m_st = 5; end
            5: begin
                if (array_ro) m_stat |= 8'h10; else m_mem[a] = d;
                if (m_cnt == 0) m_st = 6; else m_cnt--;
            end
            default: begin
                m_st = 0;
                if (c == 8'hD0) begin m_stat |= 8'h80; m_mode = 1; end
                else m_mode = 0;
            end
        endcase
    endtask

    task automatic chk(input string req, input logic [DATA_W-1:0] got, input logic [DATA_W-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input int a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = ADDR_W'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        model_wr(a, d);
    endtask

    task automatic rd_chk(input string req, input int a);
        @(negedge clk);
        rd_en = 1'b1; addr = ADDR_W'(a);
        @(negedge clk);
        rd_en = 1'b0;
        chk(req, rdata, exp_read(a));
        chk({req, " mode"}, DATA_W'(rd_mode), DATA_W'(eff_mode()));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7351));
        for (int i = 0; i < DEPTH; i++) m_mem[i] = '1;
        m_stat = 8'h80; m_st = 0; m_mode = 0; m_cnt = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_chk("R1 array after reset", 0);
        rd_chk("R1 array after reset", DEPTH - 1);
        wr(0, 16'h0070);
        rd_chk("R1 R11 status after reset", 0);
        chk("R11 lanes", rdata, 16'h8080);

        // R4 program, R8 status during sequence
        wr(0, 16'h00FF);
        wr(0, 16'h0040);
        rd_chk("R8 status while program pending", 5);
        wr(5, 16'h1234);
        rd_chk("R4 status after program", 5);
        wr(0, 16'h0010);
        wr(8, 16'hBEEF);
        wr(0, 16'h00FF);
        rd_chk("R4 programmed word", 5);
        rd_chk("R4 programmed word", 8);

        // R5 erase and abort
        wr(3, 16'h0020);
        wr(3, 16'h00FF);
        rd_chk("R5 erase abort keeps data", 5);
        wr(3, 16'h0028);
        wr(3, 16'h0077);
        rd_chk("R5 erase bad confirm", 5);
        wr(3, 16'h0020);
        wr(3, 16'h00D0);
        rd_chk("R5 erase status", 3);
        wr(0, 16'h00FF);
        rd_chk("R5 sector erased", 5);
        rd_chk("R5 next sector kept", 8);

        // R3 clear, R6 read-only
        wr(0, 16'h0050);
        rd_chk("R3 cleared status", 0);
        chk("R3 value", rdata, 16'h0000);
        array_ro = 1'b1;
        wr(8, 16'h0020);
        wr(8, 16'h00D0);
        rd_chk("R6 erase error", 8);
        chk("R6 erase error value", rdata, 16'hA0A0);
        wr(8, 16'h0010);
        wr(8, 16'h5555);
        rd_chk("R6 program error", 8);
        wr(0, 16'h00FF);
        rd_chk("R6 array unchanged", 8);
        array_ro = 1'b0;

        // R7 buffered write
        wr(0, 16'h0050);
        wr(16, 16'h00E8);
        rd_chk("R7 R8 ready set during buffer", 16);
        wr(16, 16'h0002);
        wr(16, 16'hA001);
        wr(17, 16'hA002);
        rd_chk("R8 status in buffer data", 17);
        wr(18, 16'hA003);
        wr(16, 16'h00D0);
        rd_chk("R7 status after confirm", 16);
        wr(0, 16'h00FF);
        for (int i = 16; i < 20; i++) rd_chk("R7 buffer data", i);

        // R9 lock
        wr(0, 16'h0060);
        wr(0, 16'h0001);
        rd_chk("R9 lock to status", 0);
        wr(0, 16'h0060);
        wr(0, 16'h0033);
        rd_chk("R9 lock bad value", 0);

        // R2 modes, R10 unknown
        wr(0, 16'h0090);
        rd_chk("R2 ident", 0);
        wr(0, 16'h0098);
        rd_chk("R2 query", 1);
        wr(0, 16'h0070);
        wr(0, 16'h0000);
        rd_chk("R10 unknown command", 5);

        // R12 read sees pre-edge state when write coincides
        @(negedge clk);
        rd_en = 1'b1; wr_en = 1'b1; addr = 6'd5; wdata = 16'h0070;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        chk("R12 read uses prior mode", rdata, m_mem[5]);
        model_wr(5, 16'h0070);

        // random mix
        for (int it = 0; it < 400; it++) begin
            int a = $urandom % DEPTH;
            int op = $urandom % 10;
            array_ro = (($urandom % 8) == 0);
            case (op)
                0: begin wr(a, 16'h0040); wr(a, 16'($urandom)); end
                1: begin wr(a, 16'h0020); wr(a, (($urandom % 4) != 0) ? 16'h00D0 : 16'($urandom)); end
                2: begin
                    int n = $urandom % 4;
                    wr(a, 16'h00E8); wr(a, 16'(n));
                    for (int k = 0; k <= n; k++) wr((a + k) % DEPTH, 16'($urandom));
                    wr(a, (($urandom % 4) != 0) ? 16'h00D0 : 16'h00FF);
                end
                3: begin wr(a, 16'h0060); wr(a, 16'($urandom % 3 == 0 ? 8'h01 : $urandom)); end
                4: wr(a, 16'h0050);
                5: wr(a, 16'h0070);
                6: wr(a, 16'($urandom));
                default: wr(a, 16'h00FF);
            endcase
            rd_chk("R4 R5 R6 R7 random", a);
            rd_chk("R1 R2 R11 random", $urandom % DEPTH);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule